// File: doc/BRIEF.md
# Prioritised Nested Interrupt Controller

This block gathers a parameterised set of interrupt source lines (twenty by default) and turns them into two processor requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Each request path has its own enable mask. All sources share one table of 3-bit priorities, where 0 is the most urgent. A vector word combines a programmable base value with the index of the winning source, so a handler can dispatch without scanning the status bits.

A selected subset of source lines are external pins. Each of these can be set to follow the pin level or to latch a rising or falling edge. A latched edge stays set until software clears it by writing a one to a clear register. Nesting can be enabled separately for each path. When it is on, reading a vector records the winner's priority level in a per-level status register. From then on only strictly more urgent sources can raise that path's request, until the handler writes a one to the level's bit.

Registers are reached through a single-cycle word bus. Writes take effect at the clock edge. Read data is combinational from the address. A read strobe marks a vector read.

Top module: `irqctl_top`

## Requirements
- R1: Register 0x03 reads the raw source word ANDed with the normal-path enable word, and register 0x06 does the same with the fast-path enable word. `irq_o` is high when some set bit of the 0x03 word passes the nesting filter and `fiq_o` is low.
- R2: Writing to 0x01 (normal) or 0x04 (fast) sets the enable bits written as 1. Writing to 0x02 or 0x05 clears the enable bits written as 1. Zero bits leave the enables unchanged. 0x02 and 0x05 read as zero.
- R3: Registers 0x07 (normal) and 0x08 (fast) read as a vector word. Bits [31:23] and [1:0] are zero, bits [22:7] hold the base register, and bits [6:2] hold the winning source index, or 0 when no source qualifies.
- R4: The fast request takes precedence: whenever `fiq_o` is high, `irq_o` is low.
- R5: The winner is the qualifying source with the smallest priority value, and a tie goes to the lower index. Priorities live in registers 0x10 to 0x12. Each word carries eight sources, and source 8k+j uses bits [4j+2:4j] of word 0x10+k.
- R6: Register 0x0A bit 0 enables normal-path nesting and bit 1 enables fast-path nesting. With a path's bit set, a strobed read of its vector sets bit p of its nesting register (0x0B normal, 0x0C fast), where p is the winner's priority. With the bit clear, the read changes nothing.
- R7: While a path's nesting is enabled and its nesting register is non-zero, only sources whose priority is strictly less than the lowest set nesting bit qualify on that path.
- R8: Writing 1 to a bit of 0x0B or 0x0C clears that nesting bit. If a vector read sets the same bit in the same cycle, the set wins.
- R9: For an external source in edge mode (0x0D bit = 1), a rising edge is latched, or a falling edge when its 0x0E bit is 1. The latch feeds the source bit and holds after the pin returns, until a write of 1 to the same bit position of 0x0F. The external sources are bits 13, 14, 18 and 19.
- R10: Register 0x00 reads the source word after edge handling. Sources outside the external set, and external sources in level mode, follow their pins directly, and writes to their 0x0D or 0x0E bits are ignored and read back as 0.
- R11: After reset, every enable, nesting, mode, base and priority field is 0, both requests are low and every register reads 0 with all pins low.
- R12: Register 0x09 holds a 16-bit base written from bits [15:0] and read back in the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 20 | Interrupt source lines, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Read strobe; marks vector reads for nesting |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Every cycle, the assertions check four things. The fast request masks the normal one. A winning index always points at a set status bit. A nesting-filtered winner is always strictly more urgent than the active level. A strobed vector read with nesting on leaves the winner's level bit set, and with nesting off no bit appears. They also check that edge latches hold until a clear write. Only the bench's scenarios can show the rest: tie-breaking by index, the exact vector word layout, falling-edge selection, the ignoring of mode bits on non-external sources, and nesting release through write-one-to-clear. There, a behavioural model predicts every register read and both requests.

// File: rtl/irqctl_pkg.sv
package irqctl_pkg;
   localparam int ADDR_W        = 5;
   localparam int DATA_W        = 32;
   localparam int VEC_IDX_LSB   = 2;
   localparam int VEC_IDX_MAXW  = 5;
   localparam int VEC_BASE_LSB  = 7;
   localparam int VEC_BASE_MAXW = 16;
   localparam int PRIO_FIELD    = 4;
   localparam int PRIO_PER_WORD = 8;

   localparam logic [ADDR_W-1:0] A_RAW   = 5'h00;
   localparam logic [ADDR_W-1:0] A_IEN   = 5'h01;
   localparam logic [ADDR_W-1:0] A_IDIS  = 5'h02;
   localparam logic [ADDR_W-1:0] A_ISTAT = 5'h03;
   localparam logic [ADDR_W-1:0] A_FEN   = 5'h04;
   localparam logic [ADDR_W-1:0] A_FDIS  = 5'h05;
   localparam logic [ADDR_W-1:0] A_FSTAT = 5'h06;
   localparam logic [ADDR_W-1:0] A_IVEC  = 5'h07;
   localparam logic [ADDR_W-1:0] A_FVEC  = 5'h08;
   localparam logic [ADDR_W-1:0] A_BASE  = 5'h09;
   localparam logic [ADDR_W-1:0] A_CTRL  = 5'h0A;
   localparam logic [ADDR_W-1:0] A_INEST = 5'h0B;
   localparam logic [ADDR_W-1:0] A_FNEST = 5'h0C;
   localparam logic [ADDR_W-1:0] A_ESEL  = 5'h0D;
   localparam logic [ADDR_W-1:0] A_FSEL  = 5'h0E;
   localparam logic [ADDR_W-1:0] A_ECLR  = 5'h0F;
   localparam logic [ADDR_W-1:0] A_PRIO0 = 5'h10;

   typedef struct packed {
      logic irq_nest_en;
      logic fiq_nest_en;
   } nest_ctrl_t;
endpackage

// File: rtl/irqctl_edge_cell.sv
module irqctl_edge_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic edge_mode_i,
   input  logic falling_i,
   input  logic clr_i,
   output logic sig_o,
   output logic lat_o
);
   logic prev_q, lat_q, det;

   always_comb begin
      if (falling_i) det = edge_mode_i & prev_q & ~pin_i;
      else           det = edge_mode_i & pin_i & ~prev_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= pin_i;
         lat_q  <= (lat_q & ~clr_i) | det;
      end
   end

   assign sig_o = edge_mode_i ? lat_q : pin_i;
   assign lat_o = lat_q;
endmodule

// File: rtl/irqctl_arbiter.sv
module irqctl_arbiter #(
   parameter int N  = 20,
   parameter int PW = 3,
   parameter int IW = 5
) (
   input  logic [N-1:0]    req_i,
   input  logic [N*PW-1:0] prio_i,
   input  logic            filt_i,
   input  logic [PW-1:0]   ceil_i,
   output logic            valid_o,
   output logic [IW-1:0]   idx_o,
   output logic [PW-1:0]   prio_o
);
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      prio_o  = '0;
      for (int s = 0; s < N; s++) begin
         logic [PW-1:0] p;
         logic          ok;
         p  = prio_i[s*PW +: PW];
         ok = req_i[s] && (!filt_i || (p < ceil_i));
         if (ok && (!valid_o || (p < prio_o))) begin
            valid_o = 1'b1;
            idx_o   = IW'(s);
            prio_o  = p;
         end
      end
   end
endmodule

// File: rtl/irqctl_nest.sv
module irqctl_nest #(
   parameter int PW = 3,
   localparam int NL = 1 << PW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic [PW-1:0] set_lvl_i,
   input  logic [NL-1:0] clr_i,
   output logic [NL-1:0] nest_o,
   output logic          any_o,
   output logic [PW-1:0] ceil_o
);
   logic [NL-1:0] nest_q, set_vec;

   always_comb begin
      set_vec = '0;
      if (set_i) set_vec[set_lvl_i] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nest_q <= '0;
      else        nest_q <= (nest_q & ~clr_i) | set_vec;
   end

   always_comb begin
      ceil_o = '0;
      for (int l = NL-1; l >= 0; l--) begin
         if (nest_q[l]) ceil_o = PW'(l);
      end
   end

   assign nest_o = nest_q;
   assign any_o  = |nest_q;
endmodule

// File: rtl/irqctl_top.sv
module irqctl_top #(
   parameter int                NUM_SRC  = 20,
   parameter int                PRIO_W   = 3,
   parameter int                BASE_W   = 16,
   parameter logic [NUM_SRC-1:0] EXT_MASK = 20'hC6000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [19:0]  src_i,
   input  logic         bus_we,
   input  logic         bus_re,
   input  logic [4:0]   bus_addr,
   input  logic [31:0]  bus_wdata,
   output logic [31:0]  bus_rdata,
   output logic         irq_o,
   output logic         fiq_o
);
   import irqctl_pkg::*;

   localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int NLEV       = 1 << PRIO_W;
   localparam int PRIO_WORDS = (NUM_SRC + PRIO_PER_WORD - 1) / PRIO_PER_WORD;
   localparam int PRIO_SLOTS = PRIO_WORDS * PRIO_PER_WORD;

   if (NUM_SRC != 20) begin : g_bad_ports
      $error("port width of src_i is fixed at 20 sources");
   end
   if (IDX_W > VEC_IDX_MAXW) begin : g_bad_idx
      $error("source index does not fit the vector index field");
   end
   if (BASE_W > VEC_BASE_MAXW || BASE_W < 1) begin : g_bad_base
      $error("base width does not fit the vector base field");
   end
   if (PRIO_W > PRIO_FIELD || PRIO_W < 1) begin : g_bad_prio
      $error("priority width exceeds its register field");
   end
   if (32'(A_PRIO0) + PRIO_WORDS > (1 << ADDR_W)) begin : g_bad_map
      $error("priority words overflow the address space");
   end

   logic [NUM_SRC-1:0]      ien_q, fen_q, esel_q, fsel_q;
   logic [BASE_W-1:0]       base_q;
   nest_ctrl_t              ctrl_q;
   logic [PRIO_W-1:0]       prio_q [PRIO_SLOTS];
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;

   logic [NUM_SRC-1:0]      sig, edge_lat, eclr;
   logic [NUM_SRC-1:0]      irq_stat, fiq_stat;
   logic                    wr_hit_eclr;

   logic                    irq_valid, fiq_valid;
   logic [IDX_W-1:0]        irq_idx, fiq_idx;
   logic [PRIO_W-1:0]       irq_win_prio, fiq_win_prio;
   logic [NLEV-1:0]         irq_nest, fiq_nest, inest_clr, fnest_clr;
   logic                    irq_nest_any, fiq_nest_any;
   logic [PRIO_W-1:0]       irq_ceil, fiq_ceil;
   logic                    irq_set, fiq_set;
   logic                    irq_nest_en, fiq_nest_en;

   // ---------------- edge handling on external sources ----------------
   assign wr_hit_eclr = bus_we && (bus_addr == A_ECLR);
   assign eclr        = wr_hit_eclr ? bus_wdata[NUM_SRC-1:0] : '0;

   for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_src
      if (EXT_MASK[gs]) begin : g_ext
         irqctl_edge_cell u_edge (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_i       (src_i[gs]),
            .edge_mode_i (esel_q[gs]),
            .falling_i   (fsel_q[gs]),
            .clr_i       (eclr[gs]),
            .sig_o       (sig[gs]),
            .lat_o       (edge_lat[gs])
         );
      end else begin : g_lvl
         assign sig[gs]      = src_i[gs];
         assign edge_lat[gs] = 1'b0;
      end
      assign prio_flat[gs*PRIO_W +: PRIO_W] = prio_q[gs];
   end

   assign irq_stat = sig & ien_q;
   assign fiq_stat = sig & fen_q;

   // ---------------- register writes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         fen_q  <= '0;
         esel_q <= '0;
         fsel_q <= '0;
         base_q <= '0;
         ctrl_q <= '0;
         for (int s = 0; s < PRIO_SLOTS; s++) prio_q[s] <= '0;
      end else if (bus_we) begin
         case (bus_addr)
            A_IEN:   ien_q  <= ien_q | bus_wdata[NUM_SRC-1:0];
            A_IDIS:  ien_q  <= ien_q & ~bus_wdata[NUM_SRC-1:0];
            A_FEN:   fen_q  <= fen_q | bus_wdata[NUM_SRC-1:0];
            A_FDIS:  fen_q  <= fen_q & ~bus_wdata[NUM_SRC-1:0];
            A_BASE:  base_q <= bus_wdata[BASE_W-1:0];
            A_CTRL:  ctrl_q <= '{irq_nest_en: bus_wdata[0], fiq_nest_en: bus_wdata[1]};
            A_ESEL:  esel_q <= bus_wdata[NUM_SRC-1:0] & EXT_MASK;
            A_FSEL:  fsel_q <= bus_wdata[NUM_SRC-1:0] & EXT_MASK;
            default: ;
         endcase
         for (int k = 0; k < PRIO_WORDS; k++) begin
            if (bus_addr == ADDR_W'(32'(A_PRIO0) + k)) begin
               for (int j = 0; j < PRIO_PER_WORD; j++) begin
                  if (k*PRIO_PER_WORD + j < NUM_SRC)
                     prio_q[k*PRIO_PER_WORD + j] <= bus_wdata[j*PRIO_FIELD +: PRIO_W];
               end
            end
         end
      end
   end

   assign irq_nest_en = ctrl_q.irq_nest_en;
   assign fiq_nest_en = ctrl_q.fiq_nest_en;

   // ---------------- arbitration, one per request path ----------------
   irqctl_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_arb_irq (
      .req_i   (irq_stat),
      .prio_i  (prio_flat),
      .filt_i  (irq_nest_en && irq_nest_any),
      .ceil_i  (irq_ceil),
      .valid_o (irq_valid),
      .idx_o   (irq_idx),
      .prio_o  (irq_win_prio)
   );

   irqctl_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_arb_fiq (
      .req_i   (fiq_stat),
      .prio_i  (prio_flat),
      .filt_i  (fiq_nest_en && fiq_nest_any),
      .ceil_i  (fiq_ceil),
      .valid_o (fiq_valid),
      .idx_o   (fiq_idx),
      .prio_o  (fiq_win_prio)
   );

   // ---------------- nesting state ----------------
   assign irq_set   = bus_re && (bus_addr == A_IVEC) && irq_nest_en && irq_valid;
   assign fiq_set   = bus_re && (bus_addr == A_FVEC) && fiq_nest_en && fiq_valid;
   assign inest_clr = (bus_we && bus_addr == A_INEST) ? bus_wdata[NLEV-1:0] : '0;
   assign fnest_clr = (bus_we && bus_addr == A_FNEST) ? bus_wdata[NLEV-1:0] : '0;

   irqctl_nest #(.PW(PRIO_W)) u_nest_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (irq_set),
      .set_lvl_i (irq_win_prio),
      .clr_i     (inest_clr),
      .nest_o    (irq_nest),
      .any_o     (irq_nest_any),
      .ceil_o    (irq_ceil)
   );

   irqctl_nest #(.PW(PRIO_W)) u_nest_fiq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (fiq_set),
      .set_lvl_i (fiq_win_prio),
      .clr_i     (fnest_clr),
      .nest_o    (fiq_nest),
      .any_o     (fiq_nest_any),
      .ceil_o    (fiq_ceil)
   );

   assign fiq_o = fiq_valid;
   assign irq_o = irq_valid & ~fiq_valid;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_RAW:   bus_rdata[NUM_SRC-1:0] = sig;
         A_IEN:   bus_rdata[NUM_SRC-1:0] = ien_q;
         A_ISTAT: bus_rdata[NUM_SRC-1:0] = irq_stat;
         A_FEN:   bus_rdata[NUM_SRC-1:0] = fen_q;
         A_FSTAT: bus_rdata[NUM_SRC-1:0] = fiq_stat;
         A_IVEC: begin
            bus_rdata[VEC_BASE_LSB +: BASE_W] = base_q;
            if (irq_valid) bus_rdata[VEC_IDX_LSB +: IDX_W] = irq_idx;
         end
         A_FVEC: begin
            bus_rdata[VEC_BASE_LSB +: BASE_W] = base_q;
            if (fiq_valid) bus_rdata[VEC_IDX_LSB +: IDX_W] = fiq_idx;
         end
         A_BASE:  bus_rdata[BASE_W-1:0]  = base_q;
         A_CTRL:  bus_rdata[1:0]         = {ctrl_q.fiq_nest_en, ctrl_q.irq_nest_en};
         A_INEST: bus_rdata[NLEV-1:0]    = irq_nest;
         A_FNEST: bus_rdata[NLEV-1:0]    = fiq_nest;
         A_ESEL:  bus_rdata[NUM_SRC-1:0] = esel_q;
         A_FSEL:  bus_rdata[NUM_SRC-1:0] = fsel_q;
         default: ;
      endcase
      for (int k = 0; k < PRIO_WORDS; k++) begin
         if (bus_addr == ADDR_W'(32'(A_PRIO0) + k)) begin
            for (int j = 0; j < PRIO_PER_WORD; j++)
               bus_rdata[j*PRIO_FIELD +: PRIO_W] = prio_q[k*PRIO_PER_WORD + j];
         end
      end
   end
endmodule

// File: rtl/irqctl_chk.sv
module irqctl_chk #(
   parameter int N  = 20,
   parameter int PW = 3,
   parameter int IW = 5,
   localparam int NL = 1 << PW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_we,
   input logic          bus_re,
   input logic [4:0]    bus_addr,
   input logic          irq_o,
   input logic          fiq_o,
   input logic [N-1:0]  irq_stat,
   input logic          irq_valid,
   input logic [IW-1:0] irq_idx,
   input logic [PW-1:0] irq_win_prio,
   input logic [NL-1:0] irq_nest,
   input logic          irq_nest_en,
   input logic [PW-1:0] irq_ceil,
   input logic [N-1:0]  edge_lat
);
   import irqctl_pkg::*;

   // R4: fast request masks the normal one
   p_fiq_masks_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> !irq_o);

   // R1: a normal request needs a set status bit
   p_irq_has_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|irq_stat));

   // R5: winner index points at an active source
   p_winner_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_stat[irq_idx]);

   // R7: filtered winner is strictly more urgent than the active level
   p_filter_strict_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_nest_en && (|irq_nest)) |-> (irq_win_prio < irq_ceil));

   // R6: strobed vector read records the winner's level
   p_nest_records_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == A_IVEC && irq_nest_en && irq_valid)
      |=> irq_nest[$past(irq_win_prio)]);

   // R6: with nesting off no level bit appears
   p_nest_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_nest_en |=> ((irq_nest & ~$past(irq_nest)) == '0));

   // R9: edge latches hold until a clear write
   p_latch_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == A_ECLR) |=> ((edge_lat & $past(edge_lat)) == $past(edge_lat)));
endmodule

bind irqctl_top irqctl_chk #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_we       (bus_we),
   .bus_re       (bus_re),
   .bus_addr     (bus_addr),
   .irq_o        (irq_o),
   .fiq_o        (fiq_o),
   .irq_stat     (irq_stat),
   .irq_valid    (irq_valid),
   .irq_idx      (irq_idx),
   .irq_win_prio (irq_win_prio),
   .irq_nest     (irq_nest),
   .irq_nest_en  (irq_nest_en),
   .irq_ceil     (irq_ceil),
   .edge_lat     (edge_lat)
);

// File: tb/irqctl_tb_top.sv
module irqctl_tb_top;
   localparam int          NS   = 20;
   localparam logic [19:0] EXTM = 20'hC6000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] src = '0;
   logic        we = 1'b0, re = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, fiq;

   irqctl_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we), .bus_re(re),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .irq_o(irq), .fiq_o(fiq)
   );

   always #5 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   logic [19:0] m_ien, m_fen, m_esel, m_fsel, m_lat, m_prev;
   logic [15:0] m_base;
   logic [1:0]  m_ctrl;
   logic [7:0]  m_inest, m_fnest;
   int          m_prio [NS];

   function automatic logic [19:0] m_sig();
      logic [19:0] r;
      for (int s = 0; s < NS; s++)
         r[s] = (EXTM[s] && m_esel[s]) ? m_lat[s] : src[s];
      return r;
   endfunction

   function automatic void m_win(input bit fast, output bit v, output int idx, output int pr);
      logic [19:0] act;
      logic [7:0]  nst;
      bit          filt;
      int          ceil;
      act  = m_sig() & (fast ? m_fen : m_ien);
      nst  = fast ? m_fnest : m_inest;
      filt = (fast ? m_ctrl[1] : m_ctrl[0]) && (nst != 0);
      ceil = 8;
      for (int l = 7; l >= 0; l--) if (nst[l]) ceil = l;
      v = 0; idx = 0; pr = 99;
      for (int s = 0; s < NS; s++) begin
         if (act[s] && (!filt || m_prio[s] < ceil) && m_prio[s] < pr) begin
            v = 1; idx = s; pr = m_prio[s];
         end
      end
   endfunction

   function automatic logic [31:0] m_read(input logic [4:0] a);
      bit v; int i; int p;
      logic [31:0] r;
      r = '0;
      case (a)
         5'h00: r[19:0] = m_sig();
         5'h01: r[19:0] = m_ien;
         5'h03: r[19:0] = m_sig() & m_ien;
         5'h04: r[19:0] = m_fen;
         5'h06: r[19:0] = m_sig() & m_fen;
         5'h07, 5'h08: begin
            m_win(a == 5'h08, v, i, p);
            r = {9'd0, m_base, (v ? 5'(i) : 5'd0), 2'd0};
         end
         5'h09: r[15:0] = m_base;
         5'h0A: r[1:0]  = m_ctrl;
         5'h0B: r[7:0]  = m_inest;
         5'h0C: r[7:0]  = m_fnest;
         5'h0D: r[19:0] = m_esel;
         5'h0E: r[19:0] = m_fsel;
         5'h10, 5'h11, 5'h12: begin
            for (int j = 0; j < 8; j++) begin
               int s;
               s = (int'(a) - 16) * 8 + j;
               if (s < NS) r[j*4 +: 4] = 4'(m_prio[s]);
            end
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string m_tag(input logic [4:0] a);
      if (!rst_n) return "R11";
      case (a)
         5'h00: return "R10";
         5'h01, 5'h02, 5'h04, 5'h05: return "R2";
         5'h03, 5'h06: return "R1";
         5'h07, 5'h08: return "R3 R5 R7";
         5'h09: return "R12";
         5'h0A, 5'h0B, 5'h0C: return "R6 R8";
         5'h0D, 5'h0E, 5'h0F: return "R9 R10";
         5'h10, 5'h11, 5'h12: return "R5";
         default: return "R11";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ien = '0; m_fen = '0; m_esel = '0; m_fsel = '0; m_lat = '0; m_prev = '0;
         m_base = '0; m_ctrl = '0; m_inest = '0; m_fnest = '0;
         for (int s = 0; s < NS; s++) m_prio[s] = 0;
      end else begin
         bit iv, fv; int ii, ip, fi, fp;
         logic [19:0] det;
         m_win(0, iv, ii, ip);
         m_win(1, fv, fi, fp);
         for (int s = 0; s < NS; s++) begin
            bit rise, fall;
            rise = src[s] && !m_prev[s];
            fall = !src[s] && m_prev[s];
            det[s] = EXTM[s] && m_esel[s] && (m_fsel[s] ? fall : rise);
         end
         if (we) begin
            case (addr)
               5'h01: m_ien = m_ien | wdata[19:0];
               5'h02: m_ien = m_ien & ~wdata[19:0];
               5'h04: m_fen = m_fen | wdata[19:0];
               5'h05: m_fen = m_fen & ~wdata[19:0];
               5'h09: m_base = wdata[15:0];
               5'h0A: m_ctrl = wdata[1:0];
               5'h0B: m_inest = m_inest & ~wdata[7:0];
               5'h0C: m_fnest = m_fnest & ~wdata[7:0];
               5'h0D: m_esel = wdata[19:0] & EXTM;
               5'h0E: m_fsel = wdata[19:0] & EXTM;
               5'h0F: m_lat = m_lat & ~wdata[19:0];
               5'h10, 5'h11, 5'h12: begin
                  for (int j = 0; j < 8; j++) begin
                     int s;
                     s = (int'(addr) - 16) * 8 + j;
                     if (s < NS) m_prio[s] = int'(wdata[j*4 +: 3]);
                  end
               end
               default: ;
            endcase
         end
         if (re && addr == 5'h07 && m_ctrl[0] && iv) m_inest[ip] = 1'b1;
         if (re && addr == 5'h08 && m_ctrl[1] && fv) m_fnest[fp] = 1'b1;
         m_lat  = m_lat | det;
         m_prev = src;
      end
   end

   // ---------------- per-cycle comparison ----------------
   int  n_vec = 0, n_bad = 0, cyc = 0;
   bit  chk_on = 0;

   always @(negedge clk) begin
      if (chk_on) begin
         bit iv, fv; int ii, ip, fi, fp;
         logic [31:0] exp_rd;
         m_win(0, iv, ii, ip);
         m_win(1, fv, fi, fp);
         if (!rst_n) begin iv = 0; fv = 0; end
         exp_rd = rst_n ? m_read(addr) : (addr == 5'h00 ? {12'd0, src} : 32'd0);
         n_vec++;
         // R1 R7: normal request, R4: fast masks normal
         if (irq !== (iv && !fv)) begin
            n_bad++;
            $display("FAIL R1 R4 R7 irq_o: actual %b expected %b at cycle %0d", irq, iv && !fv, cyc);
         end
         // R4 R7: fast request
         if (fiq !== fv) begin
            n_bad++;
            $display("FAIL R4 R7 fiq_o: actual %b expected %b at cycle %0d", fiq, fv, cyc);
         end
         if (rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s read 0x%0h: actual %h expected %h at cycle %0d",
                     m_tag(addr), addr, rdata, exp_rd, cyc);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge clk); #1;
      we = 0; re = 0;
   endtask
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      we = 1; addr = a; wdata = d; step();
   endtask
   task automatic peek(input logic [4:0] a);
      addr = a; step();
   endtask
   task automatic vread(input logic [4:0] a);
      re = 1; addr = a; step();
   endtask

   initial begin
      // R11: reset state of every register
      repeat (2) @(posedge clk);
      #1 chk_on = 1;
      for (int a = 0; a < 20; a++) peek(5'(a));
      rst_n = 1; #1;
      for (int a = 0; a < 20; a++) peek(5'(a));

      // R2 R1 R3 R5: enables, status, ties at equal priority go to lower index
      src = 20'h00108; peek(5'h03);
      wr(5'h01, 32'h00108); peek(5'h01); peek(5'h03); peek(5'h07);
      wr(5'h09, 32'h0000ABCD); peek(5'h09); peek(5'h07);      // R12 R3
      wr(5'h10, 32'h0000_2000);                               // source 3 -> prio 2
      peek(5'h10); peek(5'h07);                               // R5: source 8 wins
      wr(5'h11, 32'h0000_0005); peek(5'h11); peek(5'h07);     // source 8 -> prio 5, 3 wins
      wr(5'h02, 32'h00008); peek(5'h01); peek(5'h03); peek(5'h07);  // R2 disable
      wr(5'h02, 32'h0); peek(5'h01);

      // R4: fast path outranks normal path
      src = src | 20'h00020;
      wr(5'h04, 32'h00020); peek(5'h06); peek(5'h08);
      src = src & ~20'h00020; peek(5'h08);
      wr(5'h05, 32'h00020); peek(5'h04);

      // R6 R7 R8: nesting on the normal path
      src = '0;
      wr(5'h01, 32'h00504);
      wr(5'h10, 32'h0000_0100);          // source 2 -> prio 1
      wr(5'h11, 32'h0000_0404);          // source 8 -> 4, source 10 -> 4
      vread(5'h07); peek(5'h0B);         // R6: nesting off, nothing recorded
      wr(5'h0A, 32'h3); peek(5'h0A);
      src = 20'h00100; vread(5'h07); peek(5'h0B);   // level 4 recorded
      src = 20'h00500; peek(5'h07);                  // R7: same level blocked
      src = 20'h00504; peek(5'h07); vread(5'h07); peek(5'h0B);  // level 1 recorded
      wr(5'h0B, 32'h02); peek(5'h0B); peek(5'h07);   // R8: clear level 1
      wr(5'h0B, 32'h10); peek(5'h0B); peek(5'h07);
      src = '0; wr(5'h0A, 32'h0);

      // R9 R10: edge latches on external sources
      wr(5'h01, 32'hC6001);
      wr(5'h0D, 32'hFFFFF); peek(5'h0D);             // R10: only external bits stick
      wr(5'h0E, 32'h80001); peek(5'h0E);
      src = 20'h02000; peek(5'h00); src = '0; peek(5'h00); peek(5'h00);  // rising latched
      wr(5'h0F, 32'h02000); peek(5'h00);                                  // cleared
      src = 20'h80000; peek(5'h00); src = '0; peek(5'h00); peek(5'h07);   // falling latched
      wr(5'h0F, 32'h80000); peek(5'h00);
      src = 20'h00001; peek(5'h00); src = '0; peek(5'h00);               // R10 level source
      wr(5'h0D, 32'h0); src = 20'h40000; peek(5'h00); src = '0; peek(5'h00);

      // mixed random traffic over every register
      for (int n = 0; n < 600; n++) begin
         logic [4:0] a;
         src = 20'($urandom);
         a = 5'($urandom_range(0, 18));
         case ($urandom_range(0, 3))
            0: wr(a, $urandom);
            1: vread(($urandom_range(0, 1) == 1) ? 5'h07 : 5'h08);
            default: peek(a);
         endcase
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule